// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits on a 32-bit memory-mapped host bus and gives the host access to a slow register space that is addressed with 8 bits and holds one byte per location. The host never touches the slow space directly. It programs a control word that carries the remote address, the transfer direction, a size bit and byte-lane enables. Data then moves through a lower data register. A transfer runs for a fixed number of clocks. While it runs, a busy flag in the control word is set and every further control or data write is dropped.

A remote write is armed by writing the control word with the direction bit clear, and it is launched by the following write to the lower data register. A remote read is launched by the control-word write itself when the direction bit is set. When busy drops, the fetched bytes sit in the lower data register. The bridge also gathers two interrupt sources into a write-one-to-clear flag register: a level input from the slow subsystem and an internal transfer-complete event. A matching enable register masks the flags into a single interrupt line. In this project a small synchronous test memory stands in for the slow register space.

Top module: `ind_bridge_top`

## Requirements
- R1: After reset, the control word, both data registers, the enable register and the flag register read as zero, and the interrupt output is low. The identity word at offset 0x00 always reads the parameter ID_VALUE (default 32'h5A1E_0001).
- R2: Word offsets are identity 0x00, control 0x04, lower data 0x08, upper data 0x0C, interrupt enable 0x10 and interrupt flags 0x14. In the control word, bit 31 is busy (read-only), bit 25 is size, bit 24 is direction (1 = remote read), bits 23:20 are the upper-word byte enables, bits 19:16 are the lower-word byte enables, and bits 7:0 are the remote address. Every writable field reads back as written.
- R3: Writing the control word with bit 24 = 0 starts nothing. A later write to lower data while not busy starts a remote write. Busy reads 1 from the cycle after the triggering write and stays 1 for exactly 4 clocks.
- R4: Writing the control word with bit 24 = 1 while not busy starts a remote read. After busy clears, lower data holds the fetched byte zero-extended, in bits 7:0.
- R5: With size (bit 25) = 1, a transfer covers two bytes: the remote address, carried in lower data bits 7:0, and the address plus one modulo 256, carried in bits 15:8. With size = 0, only the first byte is moved.
- R6: Lower byte enable bit 16 gates byte 0 and bit 17 gates byte 1. A disabled lane is not written to the remote space, and it reads back as zero.
- R7: While busy, host writes to the control, lower data and upper data registers are ignored, and no new transfer starts.
- R8: Flag bit 1 is set while the subsystem interrupt input is high. Flag bit 0 is set when a transfer completes. Writing 1 to a flag bit clears it. A set in the same cycle wins over a clear.
- R9: The interrupt output is 1 exactly when some flag bit and the enable bit at the same position are both 1. It follows the flag and enable registers in the same cycle they change.
- R10: Read data is registered and valid in the cycle after the read strobe. It holds until the next read. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW (5) | Byte offset of the host register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| sub_irq | input | 1 | Level interrupt from the slow subsystem |
| irq | output | 1 | Masked, combined interrupt |

## Verification
On every cycle, the assertions check the following: a trigger raises busy in the next cycle, no trigger ever lands while busy, a busy period lasts exactly the access latency, the control word holds still under writes made during busy, a write-one-to-clear really clears a flag, and the interrupt output equals the masked OR of the flags. Several behaviours can only be shown by the bench scenarios. These are the bytes that actually land in and come back from the remote space, the two-byte ordering and the wrap at address 0xFF, lanes masked by the enables, and the set-beats-clear race between the subsystem input and a host clear.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  // host word indices (byte offset / 4)
  localparam int W_ID    = 0;
  localparam int W_CTRL  = 1;
  localparam int W_LDATA = 2;
  localparam int W_UDATA = 3;
  localparam int W_IEN   = 4;
  localparam int W_IFLG  = 5;

  // control word bit positions
  localparam int BUSY_BIT = 31;
  localparam int SIZE_BIT = 25;
  localparam int DIR_BIT  = 24;
  localparam int BEU_LSB  = 20;
  localparam int BEL_LSB  = 16;

  // interrupt flag positions
  localparam int FLG_XFER = 0;
  localparam int FLG_SUB  = 1;

  typedef struct packed {
    logic       size;
    logic       dir;
    logic [3:0] be_up;
    logic [3:0] be_lo;
  } ctrl_t;
endpackage

// File: rtl/ind_bridge_mem.sv
module ind_bridge_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= d;
    q <= mem[addr];
  end
endmodule

// File: rtl/ind_bridge_engine.sv
module ind_bridge_engine #(
  parameter int REG_AW     = 8,
  parameter int ACCESS_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic              size_i,
  input  logic [1:0]        be_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cap_lo_o,
  output logic              cap_hi_o,
  output logic              mem_we_o,
  output logic [REG_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_d_o
);
  localparam int CW = $clog2(ACCESS_LAT);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACCESS_LAT - 1);
  localparam logic [CW-1:0] STEP0    = CW'(2);
  localparam logic [CW-1:0] STEP1    = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          step0, step1, last;

  assign step0 = busy_o && (cnt_q == STEP0);
  assign step1 = busy_o && (cnt_q == STEP1);
  assign last  = busy_o && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (busy_o) begin
      if (last) busy_o <= 1'b0;
      else      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // byte 0 accessed in step0, byte 1 in step1; read data returns one clock later
  assign mem_addr_o = step1 ? (addr_i + REG_AW'(1)) : addr_i;
  assign mem_d_o    = step1 ? wdata_i[15:8] : wdata_i[7:0];
  assign mem_we_o   = !dir_i && ((step0 && be_i[0]) || (step1 && size_i && be_i[1]));
  assign cap_lo_o   = dir_i && step1 && be_i[0];
  assign cap_hi_o   = dir_i && last && size_i && be_i[1];
  assign done_o     = last;

  // busy period length checker
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)         run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);
  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_len == (CW+1)'(ACCESS_LAT)));
  // R7
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o);
endmodule

// File: rtl/ind_bridge_regs.sv
module ind_bridge_regs
  import ind_bridge_pkg::*;
#(
  parameter int          HOST_AW  = 5,
  parameter int          REG_AW   = 8,
  parameter logic [31:0] ID_VALUE = 32'h5A1E_0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               sub_irq,
  output logic               irq,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic               cap_lo_i,
  input  logic               cap_hi_i,
  input  logic [7:0]         mem_q_i,
  output logic               start_o,
  output ctrl_t              ctrl_o,
  output logic [REG_AW-1:0]  addr_o,
  output logic [31:0]        ldata_o
);
  localparam int IW = HOST_AW - 2;

  logic [IW-1:0] idx;
  logic          wr_acc, rd_acc;
  logic          wr_ctrl, wr_ldata, wr_udata, wr_ien, wr_iflg;
  logic [31:0]   udata_q, ctrl_word;
  logic [1:0]    ien_q, iflg_q, ien_nxt, iflg_nxt;

  assign idx      = host_addr[HOST_AW-1:2];
  assign wr_acc   = host_sel && host_wr;
  assign rd_acc   = host_sel && !host_wr;
  assign wr_ctrl  = wr_acc && !busy_i && (idx == IW'(W_CTRL));
  assign wr_ldata = wr_acc && !busy_i && (idx == IW'(W_LDATA));
  assign wr_udata = wr_acc && !busy_i && (idx == IW'(W_UDATA));
  assign wr_ien   = wr_acc && (idx == IW'(W_IEN));
  assign wr_iflg  = wr_acc && (idx == IW'(W_IFLG));

  assign start_o = (wr_ctrl && host_wdata[DIR_BIT]) || (wr_ldata && !ctrl_o.dir);

  always_comb begin
    iflg_nxt = iflg_q;
    if (wr_iflg) iflg_nxt = iflg_nxt & ~host_wdata[1:0];
    if (sub_irq) iflg_nxt[FLG_SUB]  = 1'b1;
    if (done_i)  iflg_nxt[FLG_XFER] = 1'b1;
    ien_nxt = wr_ien ? host_wdata[1:0] : ien_q;
  end

  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[BUSY_BIT]       = busy_i;
    ctrl_word[SIZE_BIT]       = ctrl_o.size;
    ctrl_word[DIR_BIT]        = ctrl_o.dir;
    ctrl_word[BEU_LSB +: 4]   = ctrl_o.be_up;
    ctrl_word[BEL_LSB +: 4]   = ctrl_o.be_lo;
    ctrl_word[REG_AW-1:0]     = addr_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o     <= '0;
      addr_o     <= '0;
      ldata_o    <= '0;
      udata_q    <= '0;
      ien_q      <= '0;
      iflg_q     <= '0;
      irq        <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_o.size  <= host_wdata[SIZE_BIT];
        ctrl_o.dir   <= host_wdata[DIR_BIT];
        ctrl_o.be_up <= host_wdata[BEU_LSB +: 4];
        ctrl_o.be_lo <= host_wdata[BEL_LSB +: 4];
        addr_o       <= host_wdata[REG_AW-1:0];
      end
      if (wr_ldata)
        ldata_o <= host_wdata;
      else if (wr_ctrl && host_wdata[DIR_BIT])
        ldata_o <= '0;
      else begin
        if (cap_lo_i) ldata_o[7:0]  <= mem_q_i;
        if (cap_hi_i) ldata_o[15:8] <= mem_q_i;
      end
      if (wr_udata) udata_q <= host_wdata;
      ien_q  <= ien_nxt;
      iflg_q <= iflg_nxt;
      irq    <= |(iflg_nxt & ien_nxt);
      if (rd_acc) begin
        case (idx)
          IW'(W_ID):    host_rdata <= ID_VALUE;
          IW'(W_CTRL):  host_rdata <= ctrl_word;
          IW'(W_LDATA): host_rdata <= ldata_o;
          IW'(W_UDATA): host_rdata <= udata_q;
          IW'(W_IEN):   host_rdata <= {30'd0, ien_q};
          IW'(W_IFLG):  host_rdata <= {30'd0, iflg_q};
          default:      host_rdata <= '0;
        endcase
      end
    end
  end

  // R7
  ctrl_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_i && wr_acc && idx == IW'(W_CTRL)) |=> ($stable(ctrl_o) && $stable(addr_o)));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && idx == IW'(W_IFLG) && host_wdata[FLG_XFER] && !done_i) |=> !iflg_q[FLG_XFER]);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(iflg_q & ien_q));
endmodule

// File: rtl/ind_bridge_top.sv
module ind_bridge_top #(
  parameter int          HOST_AW    = 5,
  parameter int          REG_AW     = 8,
  parameter int          ACCESS_LAT = 4,
  parameter logic [31:0] ID_VALUE   = 32'h5A1E_0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               sub_irq,
  output logic               irq
);
  import ind_bridge_pkg::*;

  logic              busy, done, cap_lo, cap_hi, start, mem_we;
  logic [REG_AW-1:0] mem_addr, reg_addr;
  logic [7:0]        mem_d, mem_q;
  logic [31:0]       ldata;
  ctrl_t             ctrl;

  ind_bridge_regs #(.HOST_AW(HOST_AW), .REG_AW(REG_AW), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sub_irq(sub_irq), .irq(irq),
    .busy_i(busy), .done_i(done), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
    .mem_q_i(mem_q), .start_o(start), .ctrl_o(ctrl), .addr_o(reg_addr),
    .ldata_o(ldata)
  );

  ind_bridge_engine #(.REG_AW(REG_AW), .ACCESS_LAT(ACCESS_LAT)) u_engine (
    .clk(clk), .rst(rst), .start_i(start),
    .dir_i(ctrl.dir), .size_i(ctrl.size), .be_i(ctrl.be_lo[1:0]),
    .addr_i(reg_addr), .wdata_i(ldata[15:0]),
    .busy_o(busy), .done_o(done), .cap_lo_o(cap_lo), .cap_hi_o(cap_hi),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_d_o(mem_d)
  );

  ind_bridge_mem #(.AW(REG_AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .d(mem_d), .q(mem_q)
  );
endmodule

// File: tb/tb_ind_bridge_top.sv
`timescale 1ns/1ps
module tb_ind_bridge_top;
  localparam logic [31:0] IDV = 32'h5A1E_0001;
  localparam logic [4:0] A_ID = 5'h00, A_CTRL = 5'h04, A_LO = 5'h08,
                         A_UP = 5'h0C, A_IEN = 5'h10, A_FLG = 5'h14;

  logic clk = 0, rst = 1;
  logic sel = 0, we = 0, sub = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0, n_fail = 0, cyc = 0;

  ind_bridge_top dut (
    .clk(clk), .rst(rst), .host_sel(sel), .host_wr(we), .host_addr(addr),
    .host_wdata(wd), .host_rdata(rdata), .sub_irq(sub), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_mem [256];
  bit          m_busy, m_size, m_dir;
  int          m_cnt;
  logic [3:0]  m_beu, m_bel;
  logic [7:0]  m_addr;
  logic [31:0] m_lo, m_up, m_rdata;
  logic [1:0]  m_en, m_flg;
  bit          m_irq;

  function automatic logic [31:0] m_read(input int w);
    case (w)
      0: return IDV;
      1: return {m_busy, 5'd0, m_size, m_dir, m_beu, m_bel, 8'd0, m_addr};
      2: return m_lo;
      3: return m_up;
      4: return {30'd0, m_en};
      5: return {30'd0, m_flg};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_size = 0; m_dir = 0; m_beu = 0; m_bel = 0;
      m_addr = 0; m_lo = 0; m_up = 0; m_en = 0; m_flg = 0; m_rdata = 0; m_irq = 0;
    end else begin
      int w;
      bit b_old, fin;
      logic [31:0] rv;
      logic [7:0] a1, b0, b1;
      w = int'(addr >> 2);
      rv = m_read(w);
      b_old = m_busy;
      fin = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; fin = 1;
          a1 = m_addr + 8'd1;
          if (m_dir) begin
            b0 = m_bel[0] ? m_mem[m_addr] : 8'h00;
            b1 = (m_size && m_bel[1]) ? m_mem[a1] : 8'h00;
            m_lo = {16'h0, b1, b0};
          end else begin
            if (m_bel[0]) m_mem[m_addr] = m_lo[7:0];
            if (m_size && m_bel[1]) m_mem[a1] = m_lo[15:8];
          end
        end
      end
      if (sel && we) begin
        if (!b_old && w == 1) begin
          m_size = wd[25]; m_dir = wd[24]; m_beu = wd[23:20]; m_bel = wd[19:16];
          m_addr = wd[7:0];
          if (wd[24]) begin m_busy = 1; m_cnt = 4; end
        end
        if (!b_old && w == 2) begin
          m_lo = wd;
          if (!m_dir) begin m_busy = 1; m_cnt = 4; end
        end
        if (!b_old && w == 3) m_up = wd;
        if (w == 4) m_en = wd[1:0];
        if (w == 5) m_flg = m_flg & ~wd[1:0];
      end
      if (sub) m_flg[1] = 1'b1;
      if (fin) m_flg[0] = 1'b1;
      if (sel && !we) m_rdata = rv;
      m_irq = |(m_flg & m_en);
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check("R10 rdata vs model", rdata, m_rdata);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- host access tasks (called at a negedge) ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    sel = 1; we = 1; addr = a; wd = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    sel = 1; we = 0; addr = a;
    @(negedge clk);
    sel = 0;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 50; k++) begin
      rd(A_CTRL, v);
      if (!v[31]) return;
    end
    check("R3 busy timeout", 32'd1, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int ones;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl after reset", v, 32'h0);
    rd(A_ID, v);   check("R1 identity", v, 32'h5A1E_0001);
    rd(A_LO, v);   check("R1 lower data after reset", v, 32'h0);
    rd(A_FLG, v);  check("R1 flags after reset", v, 32'h0);
    check("R1 irq after reset", {31'd0, irq}, 32'h0);

    // R2 field read-back
    wr(A_CTRL, 32'h00F3_0042);
    rd(A_CTRL, v); check("R2 ctrl readback", v, 32'h00F3_0042);
    wr(A_UP, 32'hDEAD_BEEF);
    rd(A_UP, v);   check("R2 upper data readback", v, 32'hDEAD_BEEF);

    // R10 unmapped
    rd(5'h18, v); check("R10 unmapped 0x18", v, 32'h0);
    rd(5'h1C, v); check("R10 unmapped 0x1C", v, 32'h0);

    // R3 write transfer and busy width
    wr(A_CTRL, 32'h0001_0042);
    rd(A_CTRL, v); check("R3 dir0 ctrl write starts nothing", v, 32'h0001_0042);
    wr(A_LO, 32'h0000_00A5);
    ones = 0;
    for (int k = 0; k < 6; k++) begin
      rd(A_CTRL, v);
      if (k == 0) check("R3 busy in next cycle", v, 32'h8001_0042);
      if (v[31]) ones++;
    end
    check("R3 busy length", ones, 4);

    // R4 read transfer
    wr(A_CTRL, 32'h0101_0042); wait_idle();
    rd(A_LO, v); check("R4 read byte", v, 32'h0000_00A5);

    // R7 writes during busy ignored
    wr(A_CTRL, 32'h0101_0042);
    wr(A_CTRL, 32'h0000_0077);
    wr(A_UP, 32'h1111_1111);
    wr(A_LO, 32'h1234_5678);
    wait_idle();
    rd(A_CTRL, v); check("R7 ctrl kept", v, 32'h0101_0042);
    rd(A_UP, v);   check("R7 upper data kept", v, 32'hDEAD_BEEF);
    rd(A_LO, v);   check("R7 lower data from read", v, 32'h0000_00A5);

    // R5 two-byte transfers and wrap
    wr(A_CTRL, 32'h0203_0050); wr(A_LO, 32'h0000_BEEF); wait_idle();
    wr(A_CTRL, 32'h0101_0051); wait_idle();
    rd(A_LO, v); check("R5 second byte at addr+1", v, 32'h0000_00BE);
    wr(A_CTRL, 32'h0303_0050); wait_idle();
    rd(A_LO, v); check("R5 two-byte read", v, 32'h0000_BEEF);
    wr(A_CTRL, 32'h0203_00FF); wr(A_LO, 32'h0000_1234); wait_idle();
    wr(A_CTRL, 32'h0303_00FF); wait_idle();
    rd(A_LO, v); check("R5 wrap two-byte read", v, 32'h0000_1234);
    wr(A_CTRL, 32'h0101_0000); wait_idle();
    rd(A_LO, v); check("R5 wrap lands at 0x00", v, 32'h0000_0012);

    // R6 byte enables
    wr(A_CTRL, 32'h0202_0050); wr(A_LO, 32'h0000_7766); wait_idle();
    wr(A_CTRL, 32'h0303_0050); wait_idle();
    rd(A_LO, v); check("R6 masked lane not written", v, 32'h0000_77EF);
    wr(A_CTRL, 32'h0301_0050); wait_idle();
    rd(A_LO, v); check("R6 disabled upper lane reads zero", v, 32'h0000_00EF);
    wr(A_CTRL, 32'h0102_0050); wait_idle();
    rd(A_LO, v); check("R6 disabled lower lane reads zero", v, 32'h0000_0000);

    // R8 / R9 interrupts
    rd(A_FLG, v); check("R8 completion flag", v, 32'h1);
    wr(A_FLG, 32'h1);
    rd(A_FLG, v); check("R8 write-one clears", v, 32'h0);
    wr(A_IEN, 32'h3);
    rd(A_IEN, v); check("R9 enable readback", v, 32'h3);
    check("R9 irq low with no flag", {31'd0, irq}, 32'h0);
    sub = 1; @(negedge clk); sub = 0;
    check("R9 irq from subsystem", {31'd0, irq}, 32'h1);
    rd(A_FLG, v); check("R8 subsystem flag", v, 32'h2);
    sub = 1; wr(A_FLG, 32'h2); sub = 0;
    rd(A_FLG, v); check("R8 set wins over clear", v, 32'h2);
    wr(A_FLG, 32'h2);
    rd(A_FLG, v); check("R8 subsystem flag cleared", v, 32'h0);
    check("R9 irq low after clear", {31'd0, irq}, 32'h0);
    wr(A_IEN, 32'h1);
    wr(A_CTRL, 32'h0101_0042); wait_idle();
    check("R9 irq from completion", {31'd0, irq}, 32'h1);
    wr(A_IEN, 32'h0);
    check("R9 irq masked", {31'd0, irq}, 32'h0);
    rd(A_FLG, v); check("R8 flag kept while masked", v, 32'h1);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule